// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor that reads and writes single 16-bit words and a slower word-wide main memory. It holds 128 cached blocks of 16 words each, organised as 64 sets with two ways per set. Each way keeps a tag and a valid flag, and each set keeps one replacement bit. A read that finds its block in the cache is answered from the local data array without any memory traffic. A read that misses fetches the whole block from memory one word at a time. The processor is released as soon as the word it asked for arrives, while the rest of the block keeps streaming into the array.

Writes go through to memory every time. A write that hits also updates the cached copy. A write that misses leaves the cache untouched. The processor holds a request until it sees a one-cycle ready pulse. The controller accepts a new request only after the previous access, including any remaining refill, has finished. On the memory side, the controller holds each single-word request stable until the memory acknowledges it.

Top module: `cache2w_ctrl`

## Requirements
- R1: The 16-bit word address is split into a tag in bits 15..10, a set index in bits 9..4 and a word offset in bits 3..0. A read returns the current memory content of the addressed word.
- R2: After reset every way is invalid, and cpu_ready and mem_req are low. The first read of any address therefore misses.
- R3: A read hits when the indexed set holds a valid way whose tag equals the address tag. A hit issues no memory access, and cpu_ready pulses two clock edges after the request is accepted.
- R4: When both ways of a set are valid, a miss replaces the way that was not most recently accessed. Both hits and refills count as accesses.
- R5: A miss fills an invalid way before evicting a valid one, taking way 0 first and then way 1.
- R6: A refill issues exactly 16 memory reads, one at a time, at addresses {tag, set, k} for k = 0, 1, ..., 15 in ascending order. Each request is held stable until mem_ack.
- R7: On a read miss, cpu_ready pulses with the requested word in the cycle after that word's memory acknowledge, which is after exactly offset+1 memory reads. The rest of the refill continues afterwards.
- R8: Every write produces exactly one memory write with the processor's address and data, and cpu_ready follows its acknowledge. A write hit also updates the cached word. A write miss performs no memory read and allocates nothing.
- R9: cpu_ready is a single-cycle pulse, and a new request is taken only when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |

## Verification
A directed sequence on a single set contrasts several outcomes:
- A cold miss.
- A second tag that must take the empty way rather than evict the first.
- A re-access followed by a third tag, which must evict the other block.
- Write hits against write misses.

Misses with offsets 0 and 15 pin down the point where load-through releases the processor, at the first and the last refill word. Seeded random reads and writes over four tags and four sets then mix hits, conflict evictions and write-through updates. Each access is compared with a reference model of tags, valid flags, replacement bits and memory contents, checking the number and order of memory reads, the returned data and the hit latency.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2,
        ST_WRITE  = 2'd3
    } cstate_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int TAG_W = 6,
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    output logic             lk_victim,
    input  logic [SET_W-1:0] wr_set,
    input  logic             wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inv_en,
    input  logic             fill_en,
    input  logic             touch_en,
    input  logic             touch_way
);
    localparam int WAYS = 2;
    localparam int SETS = 1 << SET_W;

    typedef struct packed {
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0] tag;
        logic [WAYS-1:0][SETS-1:0]            valid;
        logic [SETS-1:0]                      lru;
    } tstore_t;

    tstore_t ts_d, ts_q;
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = ts_q.valid[w][lk_set] && (ts_q.tag[w][lk_set] == lk_tag);
    end

    assign lk_hit = |match;
    assign lk_way = match[1];

    always_comb begin
        if (!ts_q.valid[0][lk_set])      lk_victim = 1'b0;
        else if (!ts_q.valid[1][lk_set]) lk_victim = 1'b1;
        else                             lk_victim = ts_q.lru[lk_set];
    end

    always_comb begin
        ts_d = ts_q;
        if (inv_en) begin
            ts_d.valid[wr_way][wr_set] = 1'b0;
        end
        if (fill_en) begin
            ts_d.valid[wr_way][wr_set] = 1'b1;
            ts_d.tag[wr_way][wr_set]   = wr_tag;
        end
        if (touch_en) begin
            ts_d.lru[wr_set] = ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    // R3: a block is never resident in both ways of one set
    p_no_dup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R4: an access leaves the replacement bit pointing at the other way
    p_lru_touch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> ts_q.lru[$past(wr_set)] == ~$past(touch_way));

    // R6: a completed refill makes its way valid with the new tag
    p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ts_q.valid[$past(wr_way)][$past(wr_set)]
                    && ts_q.tag[$past(wr_way)][$past(wr_set)] == $past(wr_tag));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int IDX_W  = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words_q[waddr] <= wdata;
    end

    assign rdata = words_q[raddr];

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [TAG_W+SET_W+OFF_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic [DATA_W-1:0]             cpu_rdata,
    output logic                          cpu_ready,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [TAG_W+SET_W+OFF_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic                          mem_ack,
    input  logic [DATA_W-1:0]             mem_rdata
);
    localparam int ADDR_W = TAG_W + SET_W + OFF_W;
    localparam int IDX_W  = 1 + SET_W + OFF_W;

    typedef struct packed {
        cstate_e           st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [OFF_W-1:0]  cnt;
        logic              way;
        logic [DATA_W-1:0] rdata;
        logic              ready;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [DATA_W-1:0] mwdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  a_tag;
    logic [SET_W-1:0]  a_set;
    logic [OFF_W-1:0]  a_off;
    logic              lk_hit, lk_way, lk_victim;
    logic              tw_way, inv_en, fill_en, touch_en, touch_way;
    logic              dwe;
    logic [IDX_W-1:0]  dwaddr, draddr;
    logic [DATA_W-1:0] dwdata, drdata;

    assign a_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign a_set = ctl_q.addr[OFF_W +: SET_W];
    assign a_off = ctl_q.addr[OFF_W-1:0];

    assign draddr = {lk_way, a_set, a_off};

    cache_tag_store #(
        .TAG_W (TAG_W),
        .SET_W (SET_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (a_set),
        .lk_tag    (a_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_victim (lk_victim),
        .wr_set    (a_set),
        .wr_way    (tw_way),
        .wr_tag    (a_tag),
        .inv_en    (inv_en),
        .fill_en   (fill_en),
        .touch_en  (touch_en),
        .touch_way (touch_way)
    );

    cache_data_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk   (clk),
        .we    (dwe),
        .waddr (dwaddr),
        .wdata (dwdata),
        .raddr (draddr),
        .rdata (drdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ready = 1'b0;
        tw_way    = ctl_q.way;
        inv_en    = 1'b0;
        fill_en   = 1'b0;
        touch_en  = 1'b0;
        touch_way = 1'b0;
        dwe       = 1'b0;
        dwaddr    = {ctl_q.way, a_set, ctl_q.cnt};
        dwdata    = mem_rdata;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.addr  = cpu_addr;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (ctl_q.we) begin
                    if (lk_hit) begin
                        dwe       = 1'b1;
                        dwaddr    = {lk_way, a_set, a_off};
                        dwdata    = ctl_q.wdata;
                        touch_en  = 1'b1;
                        touch_way = lk_way;
                    end
                    ctl_d.mreq   = 1'b1;
                    ctl_d.mwe    = 1'b1;
                    ctl_d.maddr  = ctl_q.addr;
                    ctl_d.mwdata = ctl_q.wdata;
                    ctl_d.st     = ST_WRITE;
                end else if (lk_hit) begin
                    ctl_d.rdata = drdata;
                    ctl_d.ready = 1'b1;
                    touch_en    = 1'b1;
                    touch_way   = lk_way;
                    ctl_d.st    = ST_IDLE;
                end else begin
                    tw_way      = lk_victim;
                    inv_en      = 1'b1;
                    ctl_d.way   = lk_victim;
                    ctl_d.cnt   = '0;
                    ctl_d.mreq  = 1'b1;
                    ctl_d.mwe   = 1'b0;
                    ctl_d.maddr = {a_tag, a_set, {OFF_W{1'b0}}};
                    ctl_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    dwe = 1'b1;
                    if (ctl_q.cnt == a_off) begin
                        ctl_d.rdata = mem_rdata;
                        ctl_d.ready = 1'b1;
                    end
                    if (ctl_q.cnt == {OFF_W{1'b1}}) begin
                        fill_en    = 1'b1;
                        touch_en   = 1'b1;
                        touch_way  = ctl_q.way;
                        ctl_d.mreq = 1'b0;
                        ctl_d.st   = ST_IDLE;
                    end else begin
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                        ctl_d.maddr = {ctl_q.maddr[ADDR_W-1:OFF_W], ctl_q.cnt + 1'b1};
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    ctl_d.mreq  = 1'b0;
                    ctl_d.mwe   = 1'b0;
                    ctl_d.ready = 1'b1;
                    ctl_d.st    = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_rdata = ctl_q.rdata;
    assign cpu_ready = ctl_q.ready;
    assign mem_req   = ctl_q.mreq;
    assign mem_we    = ctl_q.mwe;
    assign mem_addr  = ctl_q.maddr;
    assign mem_wdata = ctl_q.mwdata;

    // R9: completion is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R6: a pending memory request is held unchanged until acknowledged
    p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R6: refill addresses step upward by one word
    p_fill_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FILL && mem_ack && ctl_q.cnt != {OFF_W{1'b1}})
        |=> mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1);

    // R8: a write completes only after memory acknowledged it
    p_wt_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ctl_q.we) |-> $past(mem_ack && mem_we));

    // R3: a read hit completes next cycle without touching memory
    p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LOOKUP && lk_hit && !ctl_q.we) |=> cpu_ready && !mem_req);

endmodule

// File: tb/cache2w_ctrl_test.sv
module cache2w_ctrl_test;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2 clk = ~clk;

    cache2w_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, fails = 0;
    int nrd = 0, nwr = 0, rd_idx = 0, ord_err = 0;
    logic [15:0] exp_base = '0, last_wa = '0, last_wd = '0;
    logic [15:0] wmem [logic [15:0]];

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h13};
    endfunction

    // fixed-latency memory model
    logic        busy = 1'b0, cap_we = 1'b0;
    int          lat_cnt = 0;
    logic [15:0] cap_addr = '0, cap_wd = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            busy    <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            busy    <= 1'b0;
        end else if (!busy && mem_req) begin
            busy     <= 1'b1;
            lat_cnt  <= LAT;
            cap_addr <= mem_addr;
            cap_we   <= mem_we;
            cap_wd   <= mem_wdata;
        end else if (busy) begin
            if (lat_cnt == 0) begin
                mem_ack <= 1'b1;
                if (cap_we) begin
                    wmem[cap_addr] = cap_wd;
                    last_wa = cap_addr;
                    last_wd = cap_wd;
                    nwr++;
                end else begin
                    mem_rdata <= mem_rd(cap_addr);
                    if (cap_addr != exp_base + 16'(rd_idx)) ord_err++;
                    rd_idx++;
                    nrd++;
                end
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // reference model of tags, valid flags and replacement bits
    logic [5:0] m_tag [64][2];
    logic       m_v   [64][2];
    logic       m_lru [64];
    int         last_reads = 0;

    task automatic access(input bit we, input logic [15:0] addr, input logic [15:0] wd);
        logic [5:0] tg  = addr[15:10];
        logic [5:0] st  = addr[9:4];
        logic [3:0] off = addr[3:0];
        bit hit = 1'b0;
        bit hw  = 1'b0;
        int cyc = 0;
        int rd0 = nrd;
        int wr0 = nwr;
        logic [15:0] got;
        for (int w = 0; w < 2; w++)
            if (m_v[st][w] && m_tag[st][w] == tg) begin hit = 1'b1; hw = w[0]; end
        rd_idx   = 0;
        ord_err  = 0;
        exp_base = {tg, st, 4'd0};
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 2000);
        got = cpu_rdata;
        cpu_req = 1'b0;
        chk(cpu_ready, "R9 ready seen", {31'd0, cpu_ready}, 32'd1);
        @(negedge clk);
        chk(!cpu_ready, "R9 single-cycle ready", {31'd0, cpu_ready}, 32'd0);
        if (!we) begin
            chk(got == mem_rd(addr), "R1 read data", {16'd0, got}, {16'd0, mem_rd(addr)});
            if (hit) begin
                chk(nrd == rd0, "R3 hit has no memory read", nrd - rd0, 0);
                chk(cyc == 2, "R3 hit latency", cyc, 2);
                m_lru[st] = ~hw;
            end else begin
                chk(nrd - rd0 == int'(off) + 1, "R7 load-through point", nrd - rd0, int'(off) + 1);
                for (int k = 0; k < 2000 && nrd - rd0 < 16; k++) @(negedge clk);
                repeat (3) @(negedge clk);
                chk(nrd - rd0 == 16, "R6 refill length", nrd - rd0, 16);
                chk(ord_err == 0, "R6 refill order", ord_err, 0);
                hw = !m_v[st][0] ? 1'b0 : (!m_v[st][1] ? 1'b1 : m_lru[st]);
                m_v[st][hw]   = 1'b1;
                m_tag[st][hw] = tg;
                m_lru[st]     = ~hw;
            end
        end else begin
            chk(nwr - wr0 == 1, "R8 one memory write", nwr - wr0, 1);
            chk(last_wa == addr && last_wd == wd, "R8 write address/data",
                {last_wa, last_wd}, {addr, wd});
            chk(nrd == rd0, "R8 write causes no read", nrd - rd0, 0);
            if (hit) m_lru[st] = ~hw;
        end
        last_reads = nrd - rd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] a, b, c;
        void'($urandom(32'd4242));
        for (int s = 0; s < 64; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin m_v[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R2 reset outputs idle", {cpu_ready, mem_req}, 0);

        a = {6'd1, 6'd5, 4'd3};
        b = {6'd2, 6'd5, 4'd9};
        c = {6'd3, 6'd5, 4'd0};
        access(1'b0, a, 16'h0);
        chk(last_reads == 16, "R2 cold read misses", last_reads, 16);
        access(1'b0, b, 16'h0);
        access(1'b0, a, 16'h0);
        chk(last_reads == 0, "R5 invalid way used before eviction", last_reads, 0);
        access(1'b0, c, 16'h0);
        access(1'b0, a, 16'h0);
        chk(last_reads == 0, "R4 recently used block kept", last_reads, 0);
        access(1'b0, b, 16'h0);
        chk(last_reads == 16, "R4 least recent block evicted", last_reads, 16);
        access(1'b1, {6'd1, 6'd5, 4'd7}, 16'hBEEF);
        access(1'b0, {6'd1, 6'd5, 4'd7}, 16'h0);
        chk(last_reads == 0 && cpu_rdata == 16'hBEEF, "R8 write hit updates cache",
            {last_reads[15:0], cpu_rdata}, {16'd0, 16'hBEEF});
        access(1'b1, {6'd9, 6'd5, 4'd2}, 16'h1234);
        access(1'b0, {6'd9, 6'd5, 4'd2}, 16'h0);
        chk(last_reads == 16, "R8 write miss not allocated", last_reads, 16);
        access(1'b0, {6'd4, 6'd6, 4'd15}, 16'h0);
        chk(last_reads == 16, "R7 last-word miss", last_reads, 16);
        access(1'b0, {6'd4, 6'd7, 4'd0}, 16'h0);
        chk(last_reads == 16, "R7 first-word miss", last_reads, 16);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra;
            ra = {6'($urandom_range(0, 3)), 6'($urandom_range(8, 11)), 4'($urandom_range(0, 15))};
            access($urandom_range(0, 9) < 3, ra, 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule